// File: doc/BRIEF.md
# Two-Level Vectored Interrupt Priority Controller

This block gathers every interrupt source of a small processor subsystem into one vectored request. There are three kinds of source. One non-maskable input is edge-detected, and software picks which edge it reacts to. Six active-low external request pins can each be sensed on a low level or on a falling edge. A parameterised set of internal module request lines is also collected. Each maskable source carries a one-bit priority chosen by software, so it sits in either the high group or the low group. Inside a group, a fixed index order settles ties.

The CPU supplies two mask bits. The primary mask gates every maskable source. A mode bit decides what the second mask does: it either blocks only the low-priority group, or it is an ordinary user bit that has no effect on interrupts. The registered request, vector number and accepted level are held until the CPU acknowledges. A small register port holds the priority, enable, sense, status and control fields.

Top module: `prio_intc`

## Requirements
- R1: After reset every register reads zero and no request is raised. The register addresses are: 0 priority (one bit per source, 1 = high group), 1 external enable, 2 external status flags, 3 external sense select, 4 control (bit 0 selects the non-maskable rising edge when 1 and the falling edge when 0; bit 1 is user-bit mode).
- R2: The non-maskable input is accepted on the selected edge even when both masks are set. The opposite edge is ignored. It is reported with vector 7 and level code 2.
- R3: With sense bit 0, an external flag is set every cycle its pin is low. Acceptance does not clear it, and it is set again after a clearing write while the pin stays low.
- R4: With sense bit 1, an external flag is set only once per falling edge of its pin.
- R5: Writing 0 to a status bit clears that flag. Writing 1 leaves it unchanged.
- R6: A high-group request always wins over a low-group request, whatever their index. Level code 1 marks the high group and code 0 marks the low group.
- R7: Within one group the lowest source index wins. External line k is index k with vector 12+k. Internal line j is index 6+j with vector 18+j. The last internal line (converter complete) comes last.
- R8: With user-bit mode 0, the primary mask blocks every maskable source, and the second mask blocks only the low group.
- R9: With user-bit mode 1, the second mask has no effect, and the primary mask still blocks every maskable source.
- R10: Request, vector and level stay fixed from the cycle the request is raised until the acknowledge. The request is low in the cycle after the acknowledge.
- R11: An external flag whose enable bit is 0 is still set, but it raises no request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| nmiIn | input | 1 | Non-maskable request input |
| extIrqN | input | 6 | Active-low external request pins |
| intReq | input | NUM_INT | Internal module request levels |
| regWe | input | 1 | Register write strobe |
| regAddr | input | 3 | Register address |
| regWdata | input | 8 | Register write data |
| regRdata | output | 8 | Register read data (combinational) |
| maskI | input | 1 | CPU primary interrupt mask |
| maskU | input | 1 | CPU second mask / user bit |
| ack | input | 1 | CPU acknowledge of the current request |
| irqReq | output | 1 | Registered interrupt request |
| irqVector | output | 8 | Vector number of the held request |
| irqLevel | output | 2 | Accepted level: 0 low, 1 high, 2 non-maskable |

## Verification
The assertions assume that every input changes synchronously to the clock. They also assume the CPU raises the acknowledge for a single cycle and only while a request is held. An acknowledge with no request pending would be meaningless to the hold and drop properties. The bench changes all pins, masks and register writes on the falling clock edge. It pulses the acknowledge only after it has seen the request, and it holds the request during the acknowledge so that the controller sees it.

// File: rtl/intc_pkg.sv
package intc_pkg;
  localparam int VEC_W = 8;
  localparam int LVL_W = 2;

  // register map (R1)
  localparam logic [2:0] ADDR_PRI = 3'd0;
  localparam logic [2:0] ADDR_ENA = 3'd1;
  localparam logic [2:0] ADDR_STS = 3'd2;
  localparam logic [2:0] ADDR_SNS = 3'd3;
  localparam logic [2:0] ADDR_CTL = 3'd4;

  localparam logic [LVL_W-1:0] LVL_LOW  = 2'd0;
  localparam logic [LVL_W-1:0] LVL_HIGH = 2'd1;
  localparam logic [LVL_W-1:0] LVL_NMI  = 2'd2;

  typedef struct packed {
    logic             loadOut;
    logic             clearNmi;
    logic [VEC_W-1:0] vec;
    logic [LVL_W-1:0] lvl;
  } intcStrobe_t;
endpackage

// File: rtl/intc_datapath.sv
module intc_datapath
  import intc_pkg::*;
#(
  parameter int NUM_EXT = 6,
  parameter int NUM_INT = 2,
  parameter int DATA_W  = 8,
  parameter int ADDR_W  = 3
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        nmiIn,
  input  logic [NUM_EXT-1:0]          extIrqN,
  input  logic                        regWe,
  input  logic [ADDR_W-1:0]           regAddr,
  input  logic [DATA_W-1:0]           regWdata,
  output logic [DATA_W-1:0]           regRdata,
  input  logic                        ack,
  input  intcStrobe_t                 strobe,
  output logic                        nmiPend,
  output logic [NUM_EXT-1:0]          extFlag,
  output logic [NUM_EXT-1:0]          extEnable,
  output logic [NUM_EXT+NUM_INT-1:0]  prioLvl,
  output logic                        userMode,
  output logic                        irqReq,
  output logic [VEC_W-1:0]            irqVector,
  output logic [LVL_W-1:0]            irqLevel
);
  localparam int NUM_SRC = NUM_EXT + NUM_INT;

  logic [NUM_EXT-1:0] extSense;
  logic [NUM_EXT-1:0] extPrev;
  logic               nmiPrev;
  logic               nmiRise;
  logic               nmiEdge;
  logic               wrSts;

  assign wrSts   = regWe && (regAddr == ADDR_STS);
  // R2: edge selected by control bit 0
  assign nmiEdge = nmiRise ? (nmiIn & ~nmiPrev) : (~nmiIn & nmiPrev);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      nmiPrev  <= 1'b1;
      extPrev  <= '1;
      nmiPend  <= 1'b0;
      prioLvl  <= '0;
      extEnable <= '0;
      extSense <= '0;
      nmiRise  <= 1'b0;
      userMode <= 1'b0;
    end else begin
      nmiPrev <= nmiIn;
      extPrev <= extIrqN;
      if (nmiEdge)             nmiPend <= 1'b1;
      else if (strobe.clearNmi) nmiPend <= 1'b0;
      if (regWe) begin
        case (regAddr)
          ADDR_PRI: prioLvl   <= regWdata[NUM_SRC-1:0];
          ADDR_ENA: extEnable <= regWdata[NUM_EXT-1:0];
          ADDR_SNS: extSense  <= regWdata[NUM_EXT-1:0];
          ADDR_CTL: begin
            nmiRise  <= regWdata[0];
            userMode <= regWdata[1];
          end
          default: ;
        endcase
      end
    end
  end

  // per-line flag logic (R3, R4, R5)
  for (genvar k = 0; k < NUM_EXT; k++) begin : gFlag
    logic setFlag;
    logic clrFlag;
    assign setFlag = extSense[k] ? (extPrev[k] & ~extIrqN[k]) : ~extIrqN[k];
    assign clrFlag = wrSts & ~regWdata[k];
    always_ff @(posedge clk) begin
      if (!rstN) extFlag[k] <= 1'b0;
      else       extFlag[k] <= setFlag | (extFlag[k] & ~clrFlag);
    end
  end

  // held output registers (R10)
  always_ff @(posedge clk) begin
    if (!rstN) begin
      irqReq    <= 1'b0;
      irqVector <= '0;
      irqLevel  <= LVL_LOW;
    end else if (strobe.loadOut) begin
      irqReq    <= 1'b1;
      irqVector <= strobe.vec;
      irqLevel  <= strobe.lvl;
    end else if (ack) begin
      irqReq <= 1'b0;
    end
  end

  always_comb begin
    regRdata = '0;
    case (regAddr)
      ADDR_PRI: regRdata[NUM_SRC-1:0] = prioLvl;
      ADDR_ENA: regRdata[NUM_EXT-1:0] = extEnable;
      ADDR_STS: regRdata[NUM_EXT-1:0] = extFlag;
      ADDR_SNS: regRdata[NUM_EXT-1:0] = extSense;
      ADDR_CTL: regRdata[1:0]         = {userMode, nmiRise};
      default:  regRdata = '0;
    endcase
  end
endmodule

// File: rtl/intc_control.sv
module intc_control
  import intc_pkg::*;
#(
  parameter int NUM_EXT      = 6,
  parameter int NUM_INT      = 2,
  parameter int VEC_NMI      = 7,
  parameter int VEC_SRC_BASE = 12
) (
  input  logic                        nmiPend,
  input  logic [NUM_EXT-1:0]          extFlag,
  input  logic [NUM_EXT-1:0]          extEnable,
  input  logic [NUM_INT-1:0]          intReq,
  input  logic [NUM_EXT+NUM_INT-1:0]  prioLvl,
  input  logic                        userMode,
  input  logic                        maskI,
  input  logic                        maskU,
  input  logic                        irqReq,
  input  logic [LVL_W-1:0]            irqLevel,
  input  logic                        ack,
  output intcStrobe_t                 strobe
);
  localparam int NUM_SRC = NUM_EXT + NUM_INT;
  localparam int IDX_W   = $clog2(NUM_SRC);
  localparam logic [VEC_W-1:0] NMI_V  = VEC_W'(VEC_NMI);
  localparam logic [VEC_W-1:0] BASE_V = VEC_W'(VEC_SRC_BASE);

  logic [NUM_SRC-1:0] pending;
  logic [NUM_SRC-1:0] hiReq;
  logic [NUM_SRC-1:0] loReq;
  logic               hiOk;
  logic               loOk;
  logic [IDX_W-1:0]   hiIdx;
  logic [IDX_W-1:0]   loIdx;

  assign pending = {intReq, extFlag & extEnable};   // R11
  assign hiReq   = pending & prioLvl;
  assign loReq   = pending & ~prioLvl;
  // R8 / R9: mask interpretation
  assign hiOk = ~maskI;
  assign loOk = ~maskI & (userMode | ~maskU);

  // R7: lowest index wins inside a group
  always_comb begin
    hiIdx = '0;
    loIdx = '0;
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (hiReq[i]) hiIdx = IDX_W'(i);
      if (loReq[i]) loIdx = IDX_W'(i);
    end
  end

  always_comb begin
    strobe          = '0;
    strobe.clearNmi = irqReq & ack & (irqLevel == LVL_NMI);
    if (!irqReq) begin
      if (nmiPend) begin                       // R2
        strobe.loadOut = 1'b1;
        strobe.vec     = NMI_V;
        strobe.lvl     = LVL_NMI;
      end else if (hiOk && |hiReq) begin      // R6
        strobe.loadOut = 1'b1;
        strobe.vec     = BASE_V + VEC_W'(hiIdx);
        strobe.lvl     = LVL_HIGH;
      end else if (loOk && |loReq) begin
        strobe.loadOut = 1'b1;
        strobe.vec     = BASE_V + VEC_W'(loIdx);
        strobe.lvl     = LVL_LOW;
      end
    end
  end
endmodule

// File: rtl/prio_intc.sv
module prio_intc
  import intc_pkg::*;
#(
  parameter int NUM_INT = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               nmiIn,
  input  logic [5:0]         extIrqN,
  input  logic [NUM_INT-1:0] intReq,
  input  logic               regWe,
  input  logic [2:0]         regAddr,
  input  logic [7:0]         regWdata,
  output logic [7:0]         regRdata,
  input  logic               maskI,
  input  logic               maskU,
  input  logic               ack,
  output logic               irqReq,
  output logic [7:0]         irqVector,
  output logic [1:0]         irqLevel
);
  localparam int NUM_EXT = 6;
  localparam int NUM_SRC = NUM_EXT + NUM_INT;

  intcStrobe_t        strobe;
  logic               nmiPend;
  logic [NUM_EXT-1:0] extFlag;
  logic [NUM_EXT-1:0] extEnable;
  logic [NUM_SRC-1:0] prioLvl;
  logic               userMode;

  intc_datapath #(.NUM_EXT(NUM_EXT), .NUM_INT(NUM_INT), .DATA_W(8), .ADDR_W(3)) u_dp (
    .clk(clk), .rstN(rstN), .nmiIn(nmiIn), .extIrqN(extIrqN),
    .regWe(regWe), .regAddr(regAddr), .regWdata(regWdata), .regRdata(regRdata),
    .ack(ack), .strobe(strobe), .nmiPend(nmiPend), .extFlag(extFlag),
    .extEnable(extEnable), .prioLvl(prioLvl), .userMode(userMode),
    .irqReq(irqReq), .irqVector(irqVector), .irqLevel(irqLevel)
  );

  intc_control #(.NUM_EXT(NUM_EXT), .NUM_INT(NUM_INT), .VEC_NMI(7), .VEC_SRC_BASE(12)) u_ctl (
    .nmiPend(nmiPend), .extFlag(extFlag), .extEnable(extEnable), .intReq(intReq),
    .prioLvl(prioLvl), .userMode(userMode), .maskI(maskI), .maskU(maskU),
    .irqReq(irqReq), .irqLevel(irqLevel), .ack(ack), .strobe(strobe)
  );
endmodule

// File: rtl/prio_intc_checker.sv
module prio_intc_checker (
  input logic       clk,
  input logic       rstN,
  input logic       maskI,
  input logic       ack,
  input logic       irqReq,
  input logic [7:0] irqVector,
  input logic [1:0] irqLevel
);
  assert_hold_R10: assert property (@(posedge clk) disable iff (!rstN)
    (irqReq && !ack) |=> (irqReq && $stable(irqVector) && $stable(irqLevel)));

  assert_drop_R10: assert property (@(posedge clk) disable iff (!rstN)
    (irqReq && ack) |=> !irqReq);

  assert_maski_R8: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(irqReq) && irqLevel != 2'd2) |-> !$past(maskI));

  assert_nmivec_R2: assert property (@(posedge clk) disable iff (!rstN)
    (irqReq && irqLevel == 2'd2) |-> (irqVector == 8'd7));

  assert_lvlcode_R6: assert property (@(posedge clk) disable iff (!rstN)
    irqReq |-> (irqLevel != 2'd3));
endmodule

bind prio_intc prio_intc_checker u_chk (
  .clk(clk), .rstN(rstN), .maskI(maskI), .ack(ack),
  .irqReq(irqReq), .irqVector(irqVector), .irqLevel(irqLevel)
);

// File: tb/sim_prio_intc.sv
module sim_prio_intc;
  logic       clk = 1'b0;
  logic       rstN;
  logic       nmiIn;
  logic [5:0] extIrqN;
  logic [1:0] intReq;
  logic       regWe;
  logic [2:0] regAddr;
  logic [7:0] regWdata;
  logic [7:0] regRdata;
  logic       maskI, maskU, ack;
  logic       irqReq;
  logic [7:0] irqVector;
  logic [1:0] irqLevel;

  always #5 clk = ~clk;

  prio_intc u0 (
    .clk(clk), .rstN(rstN), .nmiIn(nmiIn), .extIrqN(extIrqN), .intReq(intReq),
    .regWe(regWe), .regAddr(regAddr), .regWdata(regWdata), .regRdata(regRdata),
    .maskI(maskI), .maskU(maskU), .ack(ack),
    .irqReq(irqReq), .irqVector(irqVector), .irqLevel(irqLevel)
  );

  typedef struct {
    logic [7:0] vec;
    logic [1:0] lvl;
    string      tag;
  } expItem_t;

  expItem_t expQ[$];
  int total = 0;
  int bad   = 0;
  bit finished = 0;

  task automatic checkVal(input string tag, input logic [31:0] act, input logic [31:0] expv);
    total++;
    if (act !== expv) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  task automatic pushExp(input logic [7:0] v, input logic [1:0] l, input string tag);
    expItem_t e;
    e.vec = v; e.lvl = l; e.tag = tag;
    expQ.push_back(e);
  endtask

  task automatic waitN(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic regWrite(input logic [2:0] a, input logic [7:0] d);
    regWe = 1'b1; regAddr = a; regWdata = d;
    @(negedge clk);
    regWe = 1'b0;
  endtask

  task automatic readReg(input logic [2:0] a, output logic [7:0] d);
    regAddr = a;
    #1;
    d = regRdata;
  endtask

  task automatic doAck();
    ack = 1'b1;
    @(negedge clk);
    ack = 1'b0;
    checkVal("R10 request low after ack", irqReq, 0);
  endtask

  task automatic summary();
    $display("test done: total=%0d bad=%0d", total, bad);
  endtask

  // monitor: compare each newly raised request with the scoreboard
  initial begin
    logic prevReq;
    expItem_t e;
    prevReq = 1'b0;
    forever begin
      @(negedge clk);
      if (rstN === 1'b1 && irqReq === 1'b1 && !prevReq) begin
        if (expQ.size() == 0) begin
          total++; bad++;
          $display("FAIL R7 unexpected request actual=%0h expected=none", irqVector);
        end else begin
          e = expQ.pop_front();
          checkVal({e.tag, " vector"}, irqVector, e.vec);
          checkVal({e.tag, " level"}, irqLevel, e.lvl);
        end
      end
      prevReq = (irqReq === 1'b1);
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=running expected=done");
      summary();
      $finish;
    end
  end

  initial begin
    logic [7:0] rd;
    rstN = 1'b0; nmiIn = 1'b1; extIrqN = '1; intReq = '0;
    regWe = 1'b0; regAddr = '0; regWdata = '0;
    maskI = 1'b0; maskU = 1'b0; ack = 1'b0;
    waitN(3);
    rstN = 1'b1;
    waitN(1);

    // R1 reset state
    for (int a = 0; a < 5; a++) begin
      readReg(3'(a), rd);
      checkVal("R1 register zero after reset", rd, 0);
    end
    checkVal("R1 no request after reset", irqReq, 0);

    // R3 level sensing on line 2
    regWrite(3'd1, 8'h04);
    pushExp(8'd14, 2'd0, "R3 level line2");
    extIrqN[2] = 1'b0;
    waitN(3);
    checkVal("R3 request raised", irqReq, 1);
    regWrite(3'd1, 8'h00);
    checkVal("R10 held after enable removed", irqReq, 1);
    checkVal("R10 vector held", irqVector, 14);
    doAck();
    readReg(3'd2, rd);
    checkVal("R3 flag kept after accept", rd[2], 1);
    regWrite(3'd2, 8'h00);
    readReg(3'd2, rd);
    checkVal("R3 flag set again while low", rd[2], 1);
    extIrqN[2] = 1'b1;
    waitN(1);
    regWrite(3'd2, 8'h00);
    readReg(3'd2, rd);
    checkVal("R5 clear by zero", rd, 0);

    // R5 / R11
    regWrite(3'd2, 8'hFF);
    readReg(3'd2, rd);
    checkVal("R5 writing ones sets nothing", rd, 0);
    extIrqN[4] = 1'b0;
    waitN(1);
    extIrqN[4] = 1'b1;
    waitN(2);
    readReg(3'd2, rd);
    checkVal("R11 flag set while disabled", rd, 8'h10);
    checkVal("R11 no request while disabled", irqReq, 0);
    regWrite(3'd2, 8'hFF);
    readReg(3'd2, rd);
    checkVal("R5 writing one keeps flag", rd, 8'h10);
    regWrite(3'd2, 8'hEF);
    readReg(3'd2, rd);
    checkVal("R5 zero bit clears flag", rd, 0);

    // R4 edge sensing on line 1
    regWrite(3'd3, 8'h02);
    regWrite(3'd1, 8'h02);
    pushExp(8'd13, 2'd0, "R4 edge line1");
    extIrqN[1] = 1'b0;
    waitN(3);
    regWrite(3'd2, 8'h00);
    doAck();
    waitN(3);
    checkVal("R4 no repeat while held low", irqReq, 0);
    readReg(3'd2, rd);
    checkVal("R4 one flag per edge", rd, 0);
    extIrqN[1] = 1'b1;
    waitN(1);
    pushExp(8'd13, 2'd0, "R4 second edge");
    extIrqN[1] = 1'b0;
    waitN(3);
    regWrite(3'd2, 8'h00);
    doAck();
    extIrqN[1] = 1'b1;
    regWrite(3'd1, 8'h00);
    regWrite(3'd3, 8'h00);

    // R6 high group beats lower index
    regWrite(3'd0, 8'h80);
    pushExp(8'd19, 2'd1, "R6 high group converter");
    pushExp(8'd18, 2'd0, "R6 low group after");
    intReq = 2'b11;
    waitN(2);
    intReq = 2'b01;
    waitN(1);
    checkVal("R10 vector stable after source drop", irqVector, 19);
    doAck();
    waitN(2);
    intReq = 2'b00;
    waitN(1);
    doAck();

    // R7 fixed order within a group
    regWrite(3'd0, 8'h00);
    regWrite(3'd1, 8'h01);
    pushExp(8'd12, 2'd0, "R7 line0 first");
    pushExp(8'd19, 2'd0, "R7 converter last");
    extIrqN[0] = 1'b0;
    waitN(1);
    intReq = 2'b10;
    waitN(2);
    regWrite(3'd1, 8'h00);
    doAck();
    waitN(2);
    intReq = 2'b00;
    extIrqN[0] = 1'b1;
    waitN(1);
    regWrite(3'd2, 8'h00);
    doAck();

    // R8 masks in mode 0, R2 through masks
    regWrite(3'd0, 8'h80);
    maskI = 1'b1;
    maskU = 1'b1;
    intReq = 2'b11;
    waitN(4);
    checkVal("R8 primary mask blocks all", irqReq, 0);
    pushExp(8'd7, 2'd2, "R2 nmi through masks");
    nmiIn = 1'b0;
    waitN(3);
    doAck();
    nmiIn = 1'b1;
    waitN(3);
    checkVal("R2 opposite edge ignored", irqReq, 0);
    maskI = 1'b0;
    pushExp(8'd19, 2'd1, "R8 high group passes second mask");
    waitN(2);
    intReq = 2'b01;
    doAck();
    waitN(3);
    checkVal("R8 second mask blocks low group", irqReq, 0);

    // R9 user-bit mode
    regWrite(3'd4, 8'h02);
    pushExp(8'd18, 2'd0, "R9 second bit ignored");
    waitN(2);
    intReq = 2'b00;
    doAck();
    maskI = 1'b1;
    intReq = 2'b01;
    waitN(4);
    checkVal("R9 primary mask still blocks", irqReq, 0);
    intReq = 2'b00;
    maskI = 1'b0;
    maskU = 1'b0;

    // R2 rising-edge select
    regWrite(3'd4, 8'h01);
    nmiIn = 1'b0;
    waitN(3);
    checkVal("R2 falling edge ignored in rising mode", irqReq, 0);
    pushExp(8'd7, 2'd2, "R2 rising edge");
    nmiIn = 1'b1;
    waitN(3);
    doAck();
    waitN(2);
    checkVal("R2 single request per edge", irqReq, 0);

    checkVal("R7 all expected requests seen", expQ.size(), 0);
    finished = 1;
    summary();
    $finish;
  end
endmodule